// File: doc/BRIEF.md
# Multicycle Issue Hazard Checker

This block is the issue-point control of an in-order pipeline whose execution units differ in latency and in how often they accept work: an integer ALU, a load path, a floating-point adder, a floating-point multiplier and an iterative divider. The divider also serves integer divide and square root. Each cycle the decode stage presents one candidate instruction. The candidate carries a valid bit, a unit code, two source register numbers and one destination register number. The block decides in the same cycle whether the candidate issues or is held. Holding is done here, after decode, and not in the fetch stages.

Inside, a small timer for each unit tracks whether it can take a new operation. A write-back calendar looks ahead one slot for each future cycle and records the destination and unit of every result already in flight. That calendar does three jobs. It serves as the in-flight destination table for read-after-write and write-after-write checks. It reserves the single register-file write port for the exact cycle a result returns. It drives the write-port outputs when that cycle arrives. Because a result that is already in flight never gives up its slot, the instruction with the longer latency always wins the port.

Top module: `fp_issue_ctl`

## Requirements
- R1: Unit codes are 0 integer (latency 0), 1 load (1), 2 FP add (3), 3 FP multiply (6) and 4 divide (24). Every unit except the divider accepts one operation per cycle. After a divide issues in cycle t, no other divide issues before cycle t+24.
- R2: A valid candidate is held while either source register equals the destination of an in-flight operation whose write-back cycle is still in the future.
- R3: A valid candidate is held while an in-flight operation with the same destination writes back in the same cycle as the candidate would, or in a later cycle.
- R4: A candidate of latency L needs the write port in cycle t+L+2. It is held if that cycle is already reserved, and the earlier reservation keeps the port. That earlier reservation always belongs to an operation of strictly longer latency.
- R5: An operation issued in cycle t with unit latency L produces exactly one write-port cycle, in cycle t+L+2. In that cycle wb_valid_o is 1, wb_reg_o is its destination and wb_unit_o is its unit code. At most one result is written per cycle.
- R6: issue_o is 1 only when id_valid_i is 1 and no hazard of R1 to R4 applies. stall_o is 1 exactly when id_valid_i is 1 and issue_o is 0. With id_valid_i at 0, both outputs are 0 and nothing is reserved.
- R7: After reset no write is pending, wb_valid_o is 0 and every unit is idle, so a divide can issue in the first cycle.
- R8: A destination stops blocking sources in the cycle its result is written. A dependent candidate issues in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| id_valid_i | input | 1 | Candidate in decode is valid |
| id_unit_i | input | 3 | Unit code of the candidate (R1 encoding) |
| id_src1_i | input | REG_W | First source register number |
| id_src2_i | input | REG_W | Second source register number |
| id_dst_i | input | REG_W | Destination register number |
| issue_o | output | 1 | Candidate issues this cycle |
| stall_o | output | 1 | Candidate is held this cycle |
| wb_valid_o | output | 1 | Write port is used this cycle |
| wb_reg_o | output | REG_W | Register written this cycle |
| wb_unit_o | output | 3 | Unit whose result is written this cycle |

## Verification
The bench first targets specific corner cases, each with a hand-computed issue distance.

- A second divide must trail the first by exactly 24 cycles. A timer off by one would let it in at 23 or hold it to 25.
- A consumer of a multiply result must issue in the very cycle the result is written. A table that frees its entry late costs one extra cycle. A table that frees it early lets the consumer read a stale value.
- A short integer write to the same register as an outstanding divide must wait until its own write-back falls after the divide's. Missing this leaves the older divide result in the register.
- Two port collisions are covered: add behind multiply, and integer behind load. A broken calendar would either write two results in one cycle or stall for the wrong number of cycles.

After that, a long pseudo-random stream over eight registers is compared cycle by cycle with a timestamp model of the same rules.

// File: rtl/fpis_pkg.sv
package fpis_pkg;
  localparam int UNIT_W    = 3;
  localparam int NUM_UNITS = 5;

  typedef enum logic [UNIT_W-1:0] {
    U_INT  = 3'd0,
    U_LOAD = 3'd1,
    U_FADD = 3'd2,
    U_FMUL = 3'd3,
    U_FDIV = 3'd4
  } unit_e;
endpackage

// File: rtl/fpis_unit_busy.sv
module fpis_unit_busy #(
  parameter int II = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = (II > 1) ? $clog2(II) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)             cnt_d = CW'(II - 1);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  assign cnt_en = start_i | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/fpis_wb_sched.sv
module fpis_wb_sched #(
  parameter int REG_W  = 5,
  parameter int UNIT_W = 3,
  parameter int DEPTH  = 26,
  parameter int K_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en_i,
  input  logic [K_W-1:0]    k_i,
  input  logic [REG_W-1:0]  src1_i,
  input  logic [REG_W-1:0]  src2_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [UNIT_W-1:0] unit_i,
  output logic              raw_hit_o,
  output logic              waw_hit_o,
  output logic              slot_taken_o,
  output logic [UNIT_W-1:0] holder_unit_o,
  output logic              wb_valid_o,
  output logic [REG_W-1:0]  wb_reg_o,
  output logic [UNIT_W-1:0] wb_unit_o
);
  // slot r holds the result that writes back r cycles from now
  logic              vld_q  [DEPTH];
  logic [REG_W-1:0]  dst_q  [DEPTH];
  logic [UNIT_W-1:0] unit_q [DEPTH];

  for (genvar r = 0; r < DEPTH; r++) begin : g_slot
    logic              up_vld;
    logic [REG_W-1:0]  up_dst;
    logic [UNIT_W-1:0] up_unit;
    logic              ins_here;
    logic              v_d, v_q, slot_en;
    logic [REG_W-1:0]  d_d, d_q;
    logic [UNIT_W-1:0] u_d, u_q;

    if (r < DEPTH - 1) begin : g_shift
      assign up_vld  = vld_q[r+1];
      assign up_dst  = dst_q[r+1];
      assign up_unit = unit_q[r+1];
    end else begin : g_end
      assign up_vld  = 1'b0;
      assign up_dst  = '0;
      assign up_unit = '0;
    end

    assign ins_here = ins_en_i && (k_i == K_W'(r + 1));
    assign v_d      = ins_here | up_vld;
    assign d_d      = ins_here ? dst_i  : up_dst;
    assign u_d      = ins_here ? unit_i : up_unit;
    assign slot_en  = ins_here | up_vld | v_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
        u_q <= '0;
      end else if (slot_en) begin
        v_q <= v_d;
        d_q <= d_d;
        u_q <= u_d;
      end
    end

    assign vld_q[r]  = v_q;
    assign dst_q[r]  = d_q;
    assign unit_q[r] = u_q;
  end

  always_comb begin
    raw_hit_o     = 1'b0;
    waw_hit_o     = 1'b0;
    slot_taken_o  = 1'b0;
    holder_unit_o = '0;
    for (int r = 1; r < DEPTH; r++) begin
      if (vld_q[r]) begin
        if (dst_q[r] == src1_i || dst_q[r] == src2_i) raw_hit_o = 1'b1;
        if (r >= int'(k_i) && dst_q[r] == dst_i)     waw_hit_o = 1'b1;
        if (r == int'(k_i)) begin
          slot_taken_o  = 1'b1;
          holder_unit_o = unit_q[r];
        end
      end
    end
  end

  assign wb_valid_o = vld_q[0];
  assign wb_reg_o   = dst_q[0];
  assign wb_unit_o  = unit_q[0];
endmodule

// File: rtl/fp_issue_ctl.sv
module fp_issue_ctl #(
  parameter int REG_W    = 5,
  parameter int LAT_INT  = 0,
  parameter int LAT_LOAD = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_FMUL = 6,
  parameter int LAT_FDIV = 24,
  parameter int II_INT   = 1,
  parameter int II_LOAD  = 1,
  parameter int II_FADD  = 1,
  parameter int II_FMUL  = 1,
  parameter int II_FDIV  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_valid_i,
  input  logic [2:0]       id_unit_i,
  input  logic [REG_W-1:0] id_src1_i,
  input  logic [REG_W-1:0] id_src2_i,
  input  logic [REG_W-1:0] id_dst_i,
  output logic             issue_o,
  output logic             stall_o,
  output logic             wb_valid_o,
  output logic [REG_W-1:0] wb_reg_o,
  output logic [2:0]       wb_unit_o
);
  import fpis_pkg::*;

  function automatic int max_lat();
    int m;
    m = LAT_INT;
    if (LAT_LOAD > m) m = LAT_LOAD;
    if (LAT_FADD > m) m = LAT_FADD;
    if (LAT_FMUL > m) m = LAT_FMUL;
    if (LAT_FDIV > m) m = LAT_FDIV;
    return m;
  endfunction

  function automatic int ii_of(int u);
    case (u)
      1:       return II_LOAD;
      2:       return II_FADD;
      3:       return II_FMUL;
      4:       return II_FDIV;
      default: return II_INT;
    endcase
  endfunction

  function automatic int lat_of(logic [UNIT_W-1:0] u);
    case (unit_e'(u))
      U_LOAD:  return LAT_LOAD;
      U_FADD:  return LAT_FADD;
      U_FMUL:  return LAT_FMUL;
      U_FDIV:  return LAT_FDIV;
      default: return LAT_INT;
    endcase
  endfunction

  localparam int DEPTH = max_lat() + 2;
  localparam int K_W   = $clog2(DEPTH + 1);

  logic [NUM_UNITS-1:0] unit_sel, unit_busy;
  logic [K_W-1:0]       wb_k;
  logic                 struct_hz, raw_hit, waw_hit, port_hz;
  logic [UNIT_W-1:0]    holder_unit;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign unit_sel[u] = (id_unit_i == UNIT_W'(u));
    fpis_unit_busy #(.II(ii_of(u))) u_busy (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (issue_o & unit_sel[u]),
      .busy_o  (unit_busy[u])
    );
  end

  assign wb_k      = K_W'(lat_of(id_unit_i) + 2);
  assign struct_hz = |(unit_busy & unit_sel);

  fpis_wb_sched #(
    .REG_W (REG_W),
    .UNIT_W(UNIT_W),
    .DEPTH (DEPTH),
    .K_W   (K_W)
  ) u_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .ins_en_i     (issue_o),
    .k_i          (wb_k),
    .src1_i       (id_src1_i),
    .src2_i       (id_src2_i),
    .dst_i        (id_dst_i),
    .unit_i       (id_unit_i),
    .raw_hit_o    (raw_hit),
    .waw_hit_o    (waw_hit),
    .slot_taken_o (port_hz),
    .holder_unit_o(holder_unit),
    .wb_valid_o   (wb_valid_o),
    .wb_reg_o     (wb_reg_o),
    .wb_unit_o    (wb_unit_o)
  );

  assign issue_o = id_valid_i & ~struct_hz & ~raw_hit & ~waw_hit & ~port_hz;
  assign stall_o = id_valid_i & ~issue_o;
endmodule

// File: rtl/fpis_issue_chk.sv
module fpis_issue_chk #(
  parameter int REG_W    = 5,
  parameter int LAT_INT  = 0,
  parameter int LAT_LOAD = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_FMUL = 6,
  parameter int LAT_FDIV = 24,
  parameter int II_FDIV  = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             id_valid,
  input logic [2:0]       id_unit,
  input logic [REG_W-1:0] id_dst,
  input logic             issue,
  input logic             stall,
  input logic             wb_valid,
  input logic [REG_W-1:0] wb_reg,
  input logic             slot_taken,
  input logic [2:0]       holder_unit
);
  function automatic int lat(logic [2:0] u);
    case (u)
      3'd1:    return LAT_LOAD;
      3'd2:    return LAT_FADD;
      3'd3:    return LAT_FMUL;
      3'd4:    return LAT_FDIV;
      default: return LAT_INT;
    endcase
  endfunction

  logic [7:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_q <= 8'hFF;
    else if (issue && id_unit == 3'd4) gap_q <= 8'h00;
    else if (gap_q != 8'hFF)           gap_q <= gap_q + 8'h01;
  end

  // R6
  a_r6_issue_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && stall));

  // R6
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> (!issue && !stall));

  // R1
  a_r1_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && id_unit == 3'd4) |-> (int'(gap_q) >= II_FDIV - 1));

  // R5
  a_r5_int_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && id_unit == 3'd0) |-> ##2 (wb_valid && wb_reg == $past(id_dst, 2)));

  // R4
  a_r4_holder_longer: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && slot_taken) |-> (lat(holder_unit) > lat(id_unit)));
endmodule

bind fp_issue_ctl fpis_issue_chk #(
  .REG_W   (REG_W),
  .LAT_INT (LAT_INT),
  .LAT_LOAD(LAT_LOAD),
  .LAT_FADD(LAT_FADD),
  .LAT_FMUL(LAT_FMUL),
  .LAT_FDIV(LAT_FDIV),
  .II_FDIV (II_FDIV)
) u_issue_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .id_valid   (id_valid_i),
  .id_unit    (id_unit_i),
  .id_dst     (id_dst_i),
  .issue      (issue_o),
  .stall      (stall_o),
  .wb_valid   (wb_valid_o),
  .wb_reg     (wb_reg_o),
  .slot_taken (port_hz),
  .holder_unit(holder_unit)
);

// File: tb/fp_issue_ctl_tb_top.sv
module fp_issue_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       id_valid;
  logic [2:0] id_unit;
  logic [4:0] id_src1, id_src2, id_dst;
  logic       issue, stall, wbv;
  logic [4:0] wbr;
  logic [2:0] wbu;

  always #2 clk = ~clk;

  fp_issue_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .id_valid_i(id_valid), .id_unit_i(id_unit),
    .id_src1_i(id_src1), .id_src2_i(id_src2), .id_dst_i(id_dst),
    .issue_o(issue), .stall_o(stall), .wb_valid_o(wbv), .wb_reg_o(wbr), .wb_unit_o(wbu)
  );

  int  total = 0;
  int  bad   = 0;
  bit  finished = 0;
  int  now = 0;
  int  last_div = 0;
  bit  div_seen = 0;
  int  last_iss = 0;
  bit  rv [32];
  int  rd [32];
  int  ru [32];
  int  rw [32];

  function automatic int lat(int u);
    case (u)
      1: return 1;
      2: return 3;
      3: return 6;
      4: return 24;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, now);
    end
  endtask

  task automatic step(input bit v, input int u, input int a, input int b, input int d, output bit did);
    bit e_st, e_raw, e_waw, e_port, e_free, e_iss, e_wbv;
    int k, e_wbr, e_wbu;
    string why;
    @(negedge clk);
    id_valid = v; id_unit = u[2:0]; id_src1 = a[4:0]; id_src2 = b[4:0]; id_dst = d[4:0];
    for (int i = 0; i < 32; i++) if (rv[i] && rw[i] < now) rv[i] = 0;
    k = lat(u) + 2;
    e_st = (u == 4) && div_seen && (now < last_div + 24);
    e_raw = 0; e_waw = 0; e_port = 0; e_free = 0; e_wbv = 0; e_wbr = 0; e_wbu = 0;
    for (int i = 0; i < 32; i++) begin
      if (rv[i]) begin
        if (rw[i] > now && (rd[i] == a || rd[i] == b)) e_raw = 1;
        if (rw[i] == now && (rd[i] == a || rd[i] == b)) e_free = 1;
        if (rw[i] >= now + k && rd[i] == d) e_waw = 1;
        if (rw[i] == now + k) e_port = 1;
        if (rw[i] == now) begin e_wbv = 1; e_wbr = rd[i]; e_wbu = ru[i]; end
      end
    end
    e_iss = v && !e_st && !e_raw && !e_waw && !e_port;
    if (!v)          why = "R6";
    else if (e_st)   why = "R1";
    else if (e_raw)  why = "R2";
    else if (e_waw)  why = "R3";
    else if (e_port) why = "R4";
    else if (e_free) why = "R8";
    else             why = "R1";
    #1;
    chk(why, issue, e_iss, "issue");
    chk("R6", stall, v && !e_iss, "stall");
    chk("R5", wbv, e_wbv, "wb_valid");
    if (e_wbv) begin
      chk("R5", wbr, e_wbr, "wb_reg");
      chk("R5", wbu, e_wbu, "wb_unit");
    end
    @(posedge clk);
    if (e_iss) begin
      for (int i = 0; i < 32; i++) begin
        if (!rv[i]) begin rv[i] = 1; rd[i] = d; ru[i] = u; rw[i] = now + k; break; end
      end
      if (u == 4) begin last_div = now; div_seen = 1; end
      last_iss = now;
    end
    now++;
    did = e_iss;
  endtask

  task automatic push(input int u, input int a, input int b, input int d);
    bit ok;
    int n = 0;
    do begin step(1, u, a, b, d, ok); n++; end while (!ok && n < 64);
  endtask

  task automatic idle(input int n);
    bit ok;
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, ok);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int t1;
    logic [31:0] lfsr;
    bit have, cv, ok;
    int cu, ca, cb, cd, m;
    for (int i = 0; i < 32; i++) rv[i] = 0;
    rst_n = 0; id_valid = 0; id_unit = 0; id_src1 = 0; id_src2 = 0; id_dst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R7", wbv, 0, "wb_valid after reset");
    chk("R7", issue, 0, "issue after reset");
    chk("R7", stall, 0, "stall after reset");
    @(posedge clk); now = 1;

    // R7: divider idle right after reset; R1: second divide 24 cycles later
    push(4, 2, 3, 1); t1 = last_iss;
    chk("R7", t1, 1, "first divide cycle");
    push(4, 5, 6, 4);
    chk("R1", last_iss - t1, 24, "divide spacing");
    idle(30);

    // R2 / R8: consumer of multiply issues in its write cycle
    push(3, 7, 8, 10); t1 = last_iss;
    push(2, 10, 9, 11);
    chk("R8", last_iss - t1, 8, "raw release distance");
    idle(12);

    // R3: short write behind long write to same register
    push(4, 0, 0, 12); t1 = last_iss;
    push(0, 1, 1, 12);
    chk("R3", last_iss - t1, 25, "waw release distance");
    idle(30);

    // R4: add collides with multiply write slot
    push(3, 1, 2, 20); t1 = last_iss;
    idle(2);
    push(2, 3, 4, 21);
    chk("R4", last_iss - t1, 4, "add behind multiply");
    idle(12);

    // R4: integer collides with load write slot
    push(1, 0, 0, 22); t1 = last_iss;
    push(0, 5, 6, 23);
    chk("R4", last_iss - t1, 2, "integer behind load");
    idle(6);

    // R1: integer unit accepts every cycle
    push(0, 27, 28, 24); t1 = last_iss;
    push(0, 27, 28, 25);
    chk("R1", last_iss - t1, 1, "back-to-back integer");
    push(0, 27, 28, 26);
    chk("R1", last_iss - t1, 2, "third integer");
    idle(30);

    // pseudo-random stream over eight registers, held while stalled
    lfsr = 32'h1ACE_5EED;
    have = 0; cv = 0; cu = 0; ca = 0; cb = 0; cd = 0;
    for (int i = 0; i < 3000; i++) begin
      if (!have) begin
        for (int j = 0; j < 19; j++) lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        cv = (lfsr[1:0] != 2'b00);
        m  = int'(lfsr[6:4]);
        cu = (m > 4) ? m - 5 : m;
        ca = int'(lfsr[10:8]);
        cb = int'(lfsr[14:12]);
        cd = int'(lfsr[18:16]);
        have = cv;
      end
      step(cv, cu, ca, cb, cd, ok);
      if (ok) have = 0;
    end
    idle(30);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule